// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block sits between the interrupt sources of a small 8-bit controller and its CPU core. It takes six request lines: two external pins, two timer overflows, and the serial receive-done and transmit-done events. It picks one request to service and presents the CPU with a code-space entry address for it. The two serial events feed a single channel and share one entry address, so six lines map onto five channels. The handler works out for itself which serial event occurred.

Requests are captured only on the cycles that the core marks with a sampling strobe, once per machine cycle. Each channel has its own enable bit and a priority bit, and a global enable gates every channel. The CPU takes a request by pulsing an acknowledge while the request output is high. This marks the granted level as in service. A return strobe later clears the most recent level. A high-level request may interrupt a running low-level handler. Nothing interrupts a running high-level handler.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `irq_o` is 0, `vec_o` is 0, `insvc_o` is 2'b00 and no pending flag is set.
- R2: Request lines are captured only on cycles with `sample_en` high. A request that is high only on cycles without the strobe has no effect.
- R3: Channel k has entry address 0003h + 8·k. The channels are ext0 (0), tmr0 (1), ext1 (2), tmr1 (3) and serial (4). `vec_o` is 0 whenever `irq_o` is low.
- R4: `req_i` bits are ext0 [0], tmr0 [1], ext1 [2], tmr1 [3], serial receive [4] and serial transmit [5]. Either serial bit alone makes channel 4 pending, with vector 0023h.
- R5: With `glb_en` low, `irq_o` stays low. A channel whose `en_i` bit is 0 is never granted.
- R6: A channel with its `prio_i` bit set to 1 (high level) is granted ahead of every low-level channel, whatever their indices.
- R7: Within one level, the pending channel with the lowest index wins.
- R8: An acknowledge while `irq_o` is high sets the in-service flag of the granted level (`insvc_o[1]` high, `insvc_o[0]` low). For channels 0 to 3 it also clears that channel's pending flag.
- R9: The acknowledge does not clear the serial pending flag. That flag takes the OR of the two serial request bits at each sampling strobe.
- R10: While the high level is in service, nothing is granted. While only the low level is in service, only high-level channels are granted.
- R11: A return strobe clears the high in-service flag if it is set, and otherwise the low one.
- R12: An acknowledge while `irq_o` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Once-per-machine-cycle request capture strobe |
| req_i | input | N_CH+1 | Raw request lines, bit order as in R4 |
| en_i | input | N_CH | Per-channel enable |
| glb_en | input | 1 | Global enable |
| prio_i | input | N_CH | Per-channel level, 1 = high |
| ack_i | input | 1 | CPU takes the offered request |
| reti_i | input | 1 | Handler return strobe |
| irq_o | output | 1 | Request offered to the CPU |
| vec_o | output | ADDR_W | Entry address of the offered channel |
| insvc_o | output | 2 | In-service flags, [1] high level, [0] low level |

## Verification
On every cycle the assertions check the masking rules and the legality of the vector: the vector must come from the address table and must belong to an enabled channel. They also check the nesting rules (no grant under a high handler, only high-level grants under a low handler) and the effect of acknowledge and return strobes on the in-service flags. Only the bench's scenarios can show which channel wins a tie or a cross-level contest. The same holds for a request that falls between sampling strobes and is lost, for a pending flag cleared by the acknowledge, and for the serial flag that survives an acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } irq_lvl_e;

   // Entry address of a channel in the low code space.
   function automatic logic [31:0] vec_addr(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned idx);
      return base + step * idx;
   endfunction

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
   parameter int N_CH  = 5,
   parameter int N_REQ = N_CH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [N_REQ-1:0] req_i,
   input  logic [N_CH-2:0]  clr_i,
   output logic [N_CH-1:0]  pend_o
);

   localparam int SHARED = N_CH - 1;

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      if (k == SHARED) begin : g_shared
         // Two events share this channel; the flag tracks their sampled OR.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_o[k] <= 1'b0;
            else if (sample_en)
               pend_o[k] <= req_i[k] | req_i[k+1];
         end
      end else begin : g_sticky
         // Set by a sampled request, cleared when the CPU takes it.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_o[k] <= 1'b0;
            else
               pend_o[k] <= (pend_o[k] & ~clr_i[k]) | (sample_en & req_i[k]);
         end
      end
   end

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
   parameter  int N_CH  = 5,
   localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0]  cand_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   // Lowest set index wins: fixed polling order within a level.
   always_comb begin
      any_o = |cand_i;
      idx_o = '0;
      for (int k = N_CH - 1; k >= 0; k--) begin
         if (cand_i[k]) idx_o = IDX_W'(k);
      end
   end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
   import irq_arb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     take_i,
   input  irq_lvl_e take_lvl_i,
   input  logic     reti_i,
   output logic [1:0] insvc_o
);

   logic hi_q, lo_q;
   logic hi_d, lo_d;

   always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      if (reti_i) begin
         if (hi_q) hi_d = 1'b0;
         else      lo_d = 1'b0;
      end
      if (take_i) begin
         if (take_lvl_i == LVL_HI) hi_d = 1'b1;
         else                      lo_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign insvc_o = {hi_q, lo_q};

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int N_CH     = 5,
   parameter int ADDR_W   = 16,
   parameter int VEC_BASE = 3,
   parameter int VEC_STEP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic [N_CH:0]     req_i,
   input  logic [N_CH-1:0]   en_i,
   input  logic              glb_en,
   input  logic [N_CH-1:0]   prio_i,
   input  logic              ack_i,
   input  logic              reti_i,
   output logic              irq_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic [1:0]        insvc_o
);

   localparam int N_REQ = N_CH + 1;
   localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam int N_LVL = 2;

   // Elaboration-time parameter checks.
   if (N_CH < 2) begin : g_bad_nch
      $error("irq_arbiter: N_CH must be at least 2");
   end
   if (VEC_STEP < 1) begin : g_bad_step
      $error("irq_arbiter: VEC_STEP must be positive");
   end
   if (longint'(VEC_BASE) + longint'(VEC_STEP) * longint'(N_CH - 1)
       >= (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("irq_arbiter: vector table exceeds address width");
   end

   logic [N_CH-1:0]  pend;
   logic [N_CH-1:0]  elig;
   logic [N_CH-1:0]  cand   [N_LVL];
   logic             any_l  [N_LVL];
   logic [IDX_W-1:0] idx_l  [N_LVL];
   logic             hi_ok, lo_ok;
   logic [IDX_W-1:0] sel_idx;
   irq_lvl_e         sel_lvl;
   logic             take;
   logic [N_CH-2:0]  clr;

   irq_pend_latch #(
      .N_CH  (N_CH),
      .N_REQ (N_REQ)
   ) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .req_i     (req_i),
      .clr_i     (clr),
      .pend_o    (pend)
   );

   assign elig = pend & en_i & {N_CH{glb_en}};

   // One picker per level; level 1 is the high level.
   for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
      assign cand[l] = (l == 1) ? (elig & prio_i) : (elig & ~prio_i);
      irq_level_pick #(
         .N_CH (N_CH)
      ) u_pick (
         .cand_i (cand[l]),
         .any_o  (any_l[l]),
         .idx_o  (idx_l[l])
      );
   end

   assign hi_ok   = any_l[1] & ~insvc_o[1];
   assign lo_ok   = any_l[0] & ~insvc_o[1] & ~insvc_o[0];
   assign irq_o   = hi_ok | lo_ok;
   assign sel_lvl = hi_ok ? LVL_HI : LVL_LO;
   assign sel_idx = hi_ok ? idx_l[1] : idx_l[0];
   assign vec_o   = irq_o
                  ? ADDR_W'(vec_addr(VEC_BASE, VEC_STEP, int'(sel_idx)))
                  : '0;
   assign take    = ack_i & irq_o;

   // Acknowledge clears the taken channel, except the shared one.
   for (genvar k = 0; k < N_CH - 1; k++) begin : g_clr
      assign clr[k] = take & (sel_idx == IDX_W'(k));
   end

   irq_nest_track u_nest (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .take_lvl_i (sel_lvl),
      .reti_i     (reti_i),
      .insvc_o    (insvc_o)
   );

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
   import irq_arb_pkg::*;
#(
   parameter int N_CH     = 5,
   parameter int ADDR_W   = 16,
   parameter int VEC_BASE = 3,
   parameter int VEC_STEP = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              glb_en,
   input logic [N_CH-1:0]   en_i,
   input logic [N_CH-1:0]   prio_i,
   input logic              ack_i,
   input logic              reti_i,
   input logic              irq_o,
   input logic [ADDR_W-1:0] vec_o,
   input logic [1:0]        insvc_o
);

   logic v_valid, en_hit, pr_hit;

   // Decode the offered vector back to a channel.
   always_comb begin
      v_valid = 1'b0;
      en_hit  = 1'b0;
      pr_hit  = 1'b0;
      for (int k = 0; k < N_CH; k++) begin
         if (vec_o == ADDR_W'(vec_addr(VEC_BASE, VEC_STEP, k))) begin
            v_valid = 1'b1;
            en_hit  = en_i[k];
            pr_hit  = prio_i[k];
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_r1: assert (!irq_o && insvc_o == 2'b00 && vec_o == '0)
            else $error("reset state wrong");
      end
   end

   p_glb_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !irq_o);

   p_ch_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> en_hit);

   p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> v_valid);

   p_vec_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> vec_o == '0);

   p_hi_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      insvc_o[1] |-> !irq_o);

   p_preempt_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && insvc_o[0]) |-> pr_hit);

   p_ack_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> insvc_o != 2'b00);

   p_reti_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !ack_i && insvc_o[1]) |=> (!insvc_o[1] && $stable(insvc_o[0])));

   p_ack_void_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o && !reti_i) |=> $stable(insvc_o));

endmodule

bind irq_arbiter irq_arbiter_chk #(
   .N_CH     (N_CH),
   .ADDR_W   (ADDR_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .glb_en  (glb_en),
   .en_i    (en_i),
   .prio_i  (prio_i),
   .ack_i   (ack_i),
   .reti_i  (reti_i),
   .irq_o   (irq_o),
   .vec_o   (vec_o),
   .insvc_o (insvc_o)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic [5:0]  req = '0;
   logic [4:0]  en = 5'h1f;
   logic        glb = 1'b1;
   logic [4:0]  prio = '0;
   logic        ack = 1'b0;
   logic        reti = 1'b0;
   logic        irq_o;
   logic [15:0] vec_o;
   logic [1:0]  insvc_o;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // Reference model state
   logic [4:0] m_pend = '0;
   logic       m_hi = 1'b0;
   logic       m_lo = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_arbiter i_irq_arbiter (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .req_i     (req),
      .en_i      (en),
      .glb_en    (glb),
      .prio_i    (prio),
      .ack_i     (ack),
      .reti_i    (reti),
      .irq_o     (irq_o),
      .vec_o     (vec_o),
      .insvc_o   (insvc_o)
   );

   function automatic void exp_out(output bit e_irq, output int e_ch, output bit e_lvl);
      logic [4:0] elig;
      elig  = m_pend & en & {NC{glb}};
      e_irq = 1'b0;
      e_ch  = 0;
      e_lvl = 1'b0;
      if (!m_hi) begin
         for (int k = NC - 1; k >= 0; k--)
            if (elig[k] && prio[k]) begin e_irq = 1'b1; e_ch = k; e_lvl = 1'b1; end
         if (!e_irq && !m_lo)
            for (int k = NC - 1; k >= 0; k--)
               if (elig[k] && !prio[k]) begin e_irq = 1'b1; e_ch = k; end
      end
   endfunction

   function automatic logic [15:0] exp_vec(input bit e_irq, input int e_ch);
      return e_irq ? 16'(3 + 8 * e_ch) : 16'h0000;
   endfunction

   task automatic chk_val(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_model(input string tag);
      bit e_irq, e_lvl;
      int e_ch;
      exp_out(e_irq, e_ch, e_lvl);
      chk_val(tag, "irq_o", 32'(irq_o), 32'(e_irq));
      chk_val(tag, "vec_o", 32'(vec_o), 32'(exp_vec(e_irq, e_ch)));
      chk_val(tag, "insvc_o", 32'(insvc_o), 32'({m_hi, m_lo}));
   endtask

   // Called at a falling edge with the inputs already set.
   task automatic step(input string tag);
      bit e_irq, e_lvl;
      int e_ch;
      exp_out(e_irq, e_ch, e_lvl);
      if (reti) begin
         if (m_hi) m_hi = 1'b0;
         else      m_lo = 1'b0;
      end
      if (ack && e_irq) begin
         if (e_lvl) m_hi = 1'b1;
         else       m_lo = 1'b1;
         if (e_ch < NC - 1) m_pend[e_ch] = 1'b0;
      end
      if (sample_en) begin
         for (int k = 0; k < NC - 1; k++)
            if (req[k]) m_pend[k] = 1'b1;
         m_pend[NC-1] = req[4] | req[5];
      end
      @(negedge clk);
      check_model(tag);
   endtask

   task automatic idle();
      sample_en = 1'b0; req = '0; ack = 1'b0; reti = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_val("R1", "irq_o", 32'(irq_o), 32'd0);
      chk_val("R1", "insvc_o", 32'(insvc_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_model("R1");

      // R2: request present without the strobe is lost
      req = 6'b000001; step("R2");
      req = '0; sample_en = 1'b1; step("R2");
      chk_val("R2", "irq_o", 32'(irq_o), 32'd0);
      idle();

      // R4 / R9: serial transmit alone, shared vector, survives acknowledge
      req = 6'b100000; sample_en = 1'b1; step("R4");
      chk_val("R4", "vec_o", 32'(vec_o), 32'h0023);
      idle(); ack = 1'b1; step("R8");
      chk_val("R8", "insvc_o", 32'(insvc_o), 32'b01);
      idle(); reti = 1'b1; step("R9");
      chk_val("R9", "vec_o", 32'(vec_o), 32'h0023);
      idle(); sample_en = 1'b1; step("R9");
      chk_val("R9", "irq_o", 32'(irq_o), 32'd0);

      // R7 / R8: same-level tie, then cleared winner
      idle(); req = 6'b000110; sample_en = 1'b1; step("R7");
      chk_val("R7", "vec_o", 32'(vec_o), 32'h000B);
      idle(); ack = 1'b1; step("R8");
      idle(); reti = 1'b1; step("R8");
      chk_val("R8", "vec_o", 32'(vec_o), 32'h0013);
      idle(); ack = 1'b1; step("R8");
      idle(); reti = 1'b1; step("R11");
      chk_val("R11", "irq_o", 32'(irq_o), 32'd0);

      // R6 / R10 / R11: cross-level and nesting
      idle(); prio = 5'b01000; req = 6'b001001; sample_en = 1'b1; step("R6");
      chk_val("R6", "vec_o", 32'(vec_o), 32'h001B);
      idle(); ack = 1'b1; step("R10");
      chk_val("R10", "insvc_o", 32'(insvc_o), 32'b10);
      chk_val("R10", "irq_o", 32'(irq_o), 32'd0);
      idle(); reti = 1'b1; step("R11");
      chk_val("R11", "vec_o", 32'(vec_o), 32'h0003);
      idle(); ack = 1'b1; step("R8");
      chk_val("R8", "insvc_o", 32'(insvc_o), 32'b01);
      idle(); prio = 5'b00010; req = 6'b000010; sample_en = 1'b1; step("R10");
      chk_val("R10", "vec_o", 32'(vec_o), 32'h000B);
      idle(); ack = 1'b1; step("R10");
      chk_val("R10", "insvc_o", 32'(insvc_o), 32'b11);
      idle(); reti = 1'b1; step("R11");
      chk_val("R11", "insvc_o", 32'(insvc_o), 32'b01);
      idle(); reti = 1'b1; step("R11");
      chk_val("R11", "insvc_o", 32'(insvc_o), 32'b00);
      idle(); prio = '0;

      // R5 / R12: masking and a void acknowledge
      req = 6'b000100; sample_en = 1'b1; glb = 1'b0; step("R5");
      chk_val("R5", "irq_o", 32'(irq_o), 32'd0);
      idle(); glb = 1'b1; en = 5'b11011; step("R5");
      chk_val("R5", "irq_o", 32'(irq_o), 32'd0);
      en = 5'h1f; step("R5");
      chk_val("R5", "vec_o", 32'(vec_o), 32'h0013);
      glb = 1'b0; ack = 1'b1; step("R12");
      chk_val("R12", "insvc_o", 32'(insvc_o), 32'b00);
      glb = 1'b1; ack = 1'b0; step("R12");
      chk_val("R12", "vec_o", 32'(vec_o), 32'h0013);
      ack = 1'b1; step("R8");
      idle(); reti = 1'b1; step("R11");
      idle();

      // Constrained random traffic checked against the model (R3 R6 R7 R10)
      for (int i = 0; i < 4000; i++) begin
         sample_en = ($urandom % 3) == 0;
         req       = 6'($urandom) & 6'($urandom);
         en        = 5'($urandom) | 5'($urandom);
         glb       = ($urandom % 8) != 0;
         prio      = 5'($urandom);
         ack       = ($urandom % 3) == 0;
         reti      = ($urandom % 6) == 0;
         step("R3 R6 R7 R10 random");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule